// File: doc/BRIEF.md
# Radix-8 Booth Modulo (2^n-1) Multiplier

This block multiplies two n-bit residues and returns their product reduced modulo 2^n-1. It is one channel of a residue-number-system arithmetic datapath: a parent places several such channels side by side, one per modulus. This block covers only the 2^n-1 channel. Because 2^n is congruent to 1 in this modulus, a multiplication by 2^i is a circular rotation and a negation is a bitwise complement. The block uses both facts throughout.

The multiplier operand is recoded into radix-8 signed digits in the range -4..4. The one hard multiple, three times the multiplicand, is formed by independent ripple-carry segments of SEG bits. Their carries are not propagated between segments. The carries travel as a sparse side word next to each partial product. The offset this representation introduces is cancelled by one constant word, computed from WIDTH and SEG during elaboration. All partial-product words, the side words and the constant are reduced by an end-around carry-save tree. One end-around-carry addition follows. An all-ones result is folded to zero. A parameter selects whether the product is registered behind an input valid strobe or leaves the block combinationally.

Top module: `m8_modmul`

## Requirements
- R1: For any operands a, b in 0..2^WIDTH-1, p equals (a*b) mod (2^WIDTH-1). An all-ones operand acts as zero.
- R2: The triple of a is built from independent SEG-bit ripple adders of a and a rotated left by one. Segment s leaves a carry of weight 2^(((s+1)*SEG) mod WIDTH). The sum word plus these weighted carries is congruent to 3a.
- R3: There are ceil(WIDTH/3) digits. Digit j is -4*b[3j+2] + 2*b[3j+1] + b[3j] + b[3j-1]. Bits above WIDTH-1 read as 0. b[-1] is b[WIDTH-1] when WIDTH is a multiple of three and 0 otherwise.
- R4: Digit j's partial product is the selected multiple (a, a rotated by 1, the triple, or a rotated by 2) rotated left by (3j mod WIDTH). For a negative digit it is complemented. A zero digit gives the zero word.
- R5: Exactly one hardwired constant word cancels the bias of the segment carries. All words are reduced before a single final end-around-carry adder.
- R6: The output p is never all ones. A zero product is presented as all zeros.
- R7: Legal SEG values are WIDTH/3 or WIDTH/6 when WIDTH is a multiple of three, and WIDTH or WIDTH/4 otherwise. SEG must divide WIDTH exactly and be at least 2. Any other combination stops elaboration.
- R8: With REG_OUT=1, a rising clock edge with in_valid=1 loads p with the product of that cycle's operands, and out_valid is 1 in the following cycle. With in_valid=0, p holds and out_valid is 0 in the following cycle.
- R9: A synchronous active-high rst forces out_valid to 0.
- R10: WIDTH is not limited to 32 bits. Widths of 40 and 48 are supported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the valid flag |
| in_valid | input | 1 | Operands a and b are valid this cycle |
| a | input | WIDTH | Multiplicand residue |
| b | input | WIDTH | Multiplier residue, Booth recoded |
| p | output | WIDTH | Product modulo 2^WIDTH-1, all-ones folded to zero |
| out_valid | output | 1 | p holds a fresh product |

## Verification
On every accepted operand pair, the assertions check three things: the registered product against a wide behavioural modulo reference, the segmented triple against 3a mod (2^WIDTH-1), and that no all-ones word ever leaves the block. They also check the valid and hold behaviour of the output register on every cycle. Only the bench scenarios can show the rest. The same operands give correct products at several widths and segment sizes. Digit patterns force every multiplier digit to +3 or -3, which exercises the compensation constant. Corner operands exercise the two zero representations. Reset clears the valid flag.

// File: rtl/m8_pkg.sv
package m8_pkg;

   // one-hot magnitude select plus sign for a radix-8 digit
   typedef struct packed {
      logic neg;
      logic one;
      logic two;
      logic three;
      logic four;
   } m8_sel_t;

   // window is {b[3j+2], b[3j+1], b[3j], b[3j-1]}
   function automatic m8_sel_t m8_recode(input logic [3:0] win);
      m8_sel_t r;
      int      v;
      int      mag;
      v     = -4 * int'(win[3]) + 2 * int'(win[2]) + int'(win[1]) + int'(win[0]);
      mag   = (v < 0) ? -v : v;
      r.neg   = (v < 0);
      r.one   = (mag == 1);
      r.two   = (mag == 2);
      r.three = (mag == 3);
      r.four  = (mag == 4);
      return r;
   endfunction

endpackage

// File: rtl/m8_hard3.sv
module m8_hard3 #(
   parameter int WIDTH = 48,
   parameter int SEG   = 16,
   localparam int NSEG = WIDTH / SEG
) (
   input  logic [WIDTH-1:0] a,
   output logic [WIDTH-1:0] h_sum,
   output logic [NSEG-1:0]  h_cy
);
   // 2a modulo 2^WIDTH-1 is a one-bit left rotation
   logic [WIDTH-1:0] dbl;
   assign dbl = {a[WIDTH-2:0], a[WIDTH-1]};

   // R2: independent ripple segments, carry kept aside
   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      assign {h_cy[s], h_sum[s*SEG +: SEG]} =
         {1'b0, a[s*SEG +: SEG]} + {1'b0, dbl[s*SEG +: SEG]};
   end
endmodule

// File: rtl/m8_pp_gen.sv
module m8_pp_gen
   import m8_pkg::*;
#(
   parameter int WIDTH = 48,
   parameter int SEG   = 16,
   parameter int IDX   = 0,
   localparam int NSEG = WIDTH / SEG,
   localparam int ROT  = (3 * IDX) % WIDTH
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] h_sum,
   input  logic [NSEG-1:0]  h_cy,
   input  logic [3:0]       win,
   output logic [WIDTH-1:0] w,
   output logic [WIDTH-1:0] v
);
   function automatic logic [WIDTH-1:0] rotl(input logic [WIDTH-1:0] x, input int sh);
      if (sh == 0) return x;
      return (x << sh) | (x >> (WIDTH - sh));
   endfunction

   m8_sel_t          sel;
   logic [WIDTH-1:0] mult;
   logic [WIDTH-1:0] rmult;

   assign sel = m8_recode(win);

   always_comb begin
      if (sel.one)        mult = a;
      else if (sel.two)   mult = rotl(a, 1);
      else if (sel.three) mult = h_sum;
      else if (sel.four)  mult = rotl(a, 2);
      else                mult = '0;
      rmult = rotl(mult, ROT);
      w     = sel.neg ? ~rmult : rmult;   // R4: -x is ~x in this modulus
   end

   // side word: bit p carries ~c, bit p+1 carries c for a positive triple;
   // together with the constant -2^p this yields +c, or -c when negated
   always_comb begin
      v = '0;
      for (int s = 0; s < NSEG; s++) begin
         int  pos;
         logic ce;
         pos = ((s + 1) * SEG + ROT) % WIDTH;
         ce  = sel.three & h_cy[s];
         v[pos]               = ~ce;
         v[(pos + 1) % WIDTH] = ce & ~sel.neg;
      end
   end
endmodule

// File: rtl/m8_eac_csa.sv
module m8_eac_csa #(
   parameter int WIDTH = 48
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic [WIDTH-1:0] z,
   output logic [WIDTH-1:0] s,
   output logic [WIDTH-1:0] c
);
   logic [WIDTH-1:0] maj;
   assign s   = x ^ y ^ z;
   assign maj = (x & y) | (x & z) | (y & z);
   // carry out of the top column wraps to bit 0 (2^WIDTH is 1)
   assign c   = {maj[WIDTH-2:0], maj[WIDTH-1]};
endmodule

// File: rtl/m8_modmul.sv
module m8_modmul
   import m8_pkg::*;
#(
   parameter int WIDTH   = 48,
   parameter int SEG     = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] p,
   output logic             out_valid
);
   localparam int NDIG = (WIDTH + 2) / 3;
   localparam int NSEG = WIDTH / SEG;
   localparam int NOP  = 2 * NDIG + 1;
   localparam bit DIV3 = (WIDTH % 3 == 0);
   localparam bit LEGAL = (SEG >= 2) && (WIDTH % SEG == 0) &&
      (DIV3 ? (SEG == WIDTH / 3 || (WIDTH % 6 == 0 && SEG == WIDTH / 6))
            : (SEG == WIDTH     || (WIDTH % 4 == 0 && SEG == WIDTH / 4)));

   // R7: reject unsupported width / segment pairs
   if (!LEGAL || WIDTH < 4) begin : g_bad_cfg
      $error("m8_modmul: SEG=%0d not supported for WIDTH=%0d", SEG, WIDTH);
   end

   function automatic int cnt_at(input int lvl);
      int c;
      c = NOP;
      for (int i = 0; i < lvl; i++) c = (c / 3) * 2 + c % 3;
      return c;
   endfunction

   function automatic int lvl_count();
      int c;
      int l;
      c = NOP;
      l = 0;
      while (c > 2) begin
         c = (c / 3) * 2 + c % 3;
         l++;
      end
      return l;
   endfunction

   // R5: negated sum of every side-word bias 2^p, modulo 2^WIDTH-1
   function automatic logic [WIDTH-1:0] comp_word();
      logic [WIDTH:0] acc;
      acc = '0;
      for (int j = 0; j < NDIG; j++) begin
         for (int s = 0; s < NSEG; s++) begin
            acc = {1'b0, acc[WIDTH-1:0]} + ((WIDTH+1)'(1) << (((s + 1) * SEG + 3 * j) % WIDTH));
            acc = {1'b0, acc[WIDTH-1:0]} + (WIDTH+1)'(acc[WIDTH]);
         end
      end
      return ~acc[WIDTH-1:0];
   endfunction

   localparam int NLVL = lvl_count();
   localparam logic [WIDTH-1:0] KCOMP = comp_word();

   logic [WIDTH-1:0] h_sum;
   logic [NSEG-1:0]  h_cy;
   logic [3*NDIG:0]  bext;
   logic [WIDTH-1:0] ops [NLVL+1][NOP];
   logic [WIDTH:0]   fsum;
   logic [WIDTH-1:0] fres;
   logic [WIDTH-1:0] p_comb;

   m8_hard3 #(.WIDTH(WIDTH), .SEG(SEG)) u_hard3 (
      .a     (a),
      .h_sum (h_sum),
      .h_cy  (h_cy)
   );

   // R3: circular low bit only when the digits tile the word exactly
   always_comb begin
      bext          = '0;
      bext[WIDTH:1] = b;
      bext[0]       = DIV3 ? b[WIDTH-1] : 1'b0;
   end

   for (genvar j = 0; j < NDIG; j++) begin : g_dig
      m8_pp_gen #(.WIDTH(WIDTH), .SEG(SEG), .IDX(j)) u_pp (
         .a     (a),
         .h_sum (h_sum),
         .h_cy  (h_cy),
         .win   (bext[3*j +: 4]),
         .w     (ops[0][j]),
         .v     (ops[0][NDIG+j])
      );
   end
   assign ops[0][2*NDIG] = KCOMP;

   // end-around carry-save tree, one row of 3:2 compressors per level
   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      localparam int CI = cnt_at(l);
      localparam int CO = cnt_at(l + 1);
      localparam int NG = CI / 3;
      for (genvar g = 0; g < NG; g++) begin : g_csa
         m8_eac_csa #(.WIDTH(WIDTH)) u_csa (
            .x (ops[l][3*g]),
            .y (ops[l][3*g+1]),
            .z (ops[l][3*g+2]),
            .s (ops[l+1][2*g]),
            .c (ops[l+1][2*g+1])
         );
      end
      for (genvar m = 3 * NG; m < CI; m++) begin : g_pass
         assign ops[l+1][2*NG + m - 3*NG] = ops[l][m];
      end
      for (genvar m = CO; m < NOP; m++) begin : g_tie
         assign ops[l+1][m] = '0;
      end
   end

   // single end-around-carry adder, then fold all-ones to zero (R6)
   always_comb begin
      fsum   = {1'b0, ops[NLVL][0]} + {1'b0, ops[NLVL][1]};
      fres   = fsum[WIDTH-1:0] + WIDTH'(fsum[WIDTH]);
      p_comb = (&fres) ? '0 : fres;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) out_valid <= 1'b0;
         else     out_valid <= in_valid;
         if (in_valid) p <= p_comb;
      end
   end else begin : g_comb
      assign p         = p_comb;
      assign out_valid = in_valid;
   end

   // ---------------- assertions ----------------
   localparam logic [WIDTH-1:0] ALL1 = '1;

   function automatic logic [WIDTH-1:0] hard_value(input logic [WIDTH-1:0] hs,
                                                   input logic [NSEG-1:0] hc);
      logic [WIDTH:0] acc;
      acc = {1'b0, hs};
      for (int s = 0; s < NSEG; s++) begin
         acc = {1'b0, acc[WIDTH-1:0]} + ((WIDTH+1)'(hc[s]) << (((s + 1) * SEG) % WIDTH));
         acc = {1'b0, acc[WIDTH-1:0]} + (WIDTH+1)'(acc[WIDTH]);
      end
      return (&acc[WIDTH-1:0]) ? '0 : acc[WIDTH-1:0];
   endfunction

   logic [WIDTH-1:0] ref_prod;
   logic [WIDTH-1:0] ref_triple;
   always_comb begin
      ref_prod   = WIDTH'(({{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b}) % {{WIDTH{1'b0}}, ALL1});
      ref_triple = WIDTH'(({2'b00, a} * (WIDTH+2)'(3)) % {2'b00, ALL1});
   end

   a_r2_triple_value: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> hard_value(h_sum, h_cy) == ref_triple);

   if (REG_OUT) begin : g_chk
      a_r1_product: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> p == $past(ref_prod));
      a_r6_no_all_ones: assert property (@(posedge clk) disable iff (rst)
         out_valid |-> p != ALL1);
      a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid);
      a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> !out_valid);
      a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
         !in_valid |=> $stable(p));
   end
endmodule

// File: tb/tb_m8_modmul.sv
`timescale 1ns/1ps
module tb_m8_modmul;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [7:0]  a8,  b8,  p8x,  p8y;
   logic [11:0] a12, b12, p12x, p12y;
   logic [39:0] a40, b40, p40x, p40y;
   logic [47:0] a48, b48, p48x, p48y;
   logic [7:0]  ov;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   m8_modmul #(.WIDTH(8),  .SEG(8))  dut   (.clk, .rst, .in_valid, .a(a8),  .b(b8),  .p(p8x),  .out_valid(ov[0]));
   m8_modmul #(.WIDTH(8),  .SEG(2))  dut1  (.clk, .rst, .in_valid, .a(a8),  .b(b8),  .p(p8y),  .out_valid(ov[1]));
   m8_modmul #(.WIDTH(12), .SEG(4))  dut2  (.clk, .rst, .in_valid, .a(a12), .b(b12), .p(p12x), .out_valid(ov[2]));
   m8_modmul #(.WIDTH(12), .SEG(2))  dut3  (.clk, .rst, .in_valid, .a(a12), .b(b12), .p(p12y), .out_valid(ov[3]));
   m8_modmul #(.WIDTH(40), .SEG(40)) dut4  (.clk, .rst, .in_valid, .a(a40), .b(b40), .p(p40x), .out_valid(ov[4]));
   m8_modmul #(.WIDTH(40), .SEG(10)) dut5  (.clk, .rst, .in_valid, .a(a40), .b(b40), .p(p40y), .out_valid(ov[5]));
   m8_modmul #(.WIDTH(48), .SEG(16)) dut6  (.clk, .rst, .in_valid, .a(a48), .b(b48), .p(p48x), .out_valid(ov[6]));
   m8_modmul #(.WIDTH(48), .SEG(8))  dut7  (.clk, .rst, .in_valid, .a(a48), .b(b48), .p(p48y), .out_valid(ov[7]));

   function automatic logic [63:0] refm(input logic [63:0] x, input logic [63:0] y, input int n);
      logic [127:0] m;
      m = (128'd1 << n) - 128'd1;
      return 64'((128'(x) * 128'(y)) % m);
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic drive(input logic [63:0] x, input logic [63:0] y);
      @(negedge clk);
      a8 = x[7:0];   b8 = y[7:0];
      a12 = x[11:0]; b12 = y[11:0];
      a40 = x[39:0]; b40 = y[39:0];
      a48 = x[47:0]; b48 = y[47:0];
      in_valid = 1'b1;
      @(negedge clk);   // one capture edge has passed
   endtask

   task automatic check_all(input string req);
      chk(req, "w8 s8",   64'(p8x),  refm(64'(a8),  64'(b8),  8));
      chk(req, "w8 s2",   64'(p8y),  refm(64'(a8),  64'(b8),  8));
      chk(req, "w12 s4",  64'(p12x), refm(64'(a12), 64'(b12), 12));
      chk(req, "w12 s2",  64'(p12y), refm(64'(a12), 64'(b12), 12));
      chk(req, "w40 s40", 64'(p40x), refm(64'(a40), 64'(b40), 40));
      chk(req, "w40 s10", 64'(p40y), refm(64'(a40), 64'(b40), 40));
      chk(req, "w48 s16", 64'(p48x), refm(64'(a48), 64'(b48), 48));
      chk(req, "w48 s8",  64'(p48y), refm(64'(a48), 64'(b48), 48));
      chk(req, "valid",   64'(ov),   64'hFF);
   endtask

   // R9: valid flag cleared under reset even with in_valid high
   task automatic t_reset();
      rst = 1'b1;
      in_valid = 1'b1;
      a8 = '1; b8 = '1; a12 = '1; b12 = '1; a40 = '1; b40 = '1; a48 = '1; b48 = '1;
      repeat (3) @(negedge clk);
      chk("R9", "out_valid in reset", 64'(ov), 64'h0);
      rst = 1'b0;
   endtask

   // R1, R6: both zero forms, one, and 2^n-2
   task automatic t_corners();
      logic [63:0] vals [4];
      vals[0] = 64'h0;
      vals[1] = 64'h1;
      vals[2] = 64'hFFFF_FFFF_FFFF_FFFE;
      vals[3] = 64'hFFFF_FFFF_FFFF_FFFF;
      for (int i = 0; i < 4; i++)
         for (int k = 0; k < 4; k++) begin
            drive(vals[i], vals[k]);
            check_all("R1");
            chk("R6", "w48 not all ones", 64'(&p48y), 64'h0);
         end
   endtask

   // R2, R3, R4: digits all +3 (octal 3s) and mostly -3 (octal 4s)
   task automatic t_digits();
      logic [63:0] pats [4];
      pats[0] = 64'o0333333333333333333333;
      pats[1] = 64'o0444444444444444444444;
      pats[2] = 64'o0777777777777777777777;
      pats[3] = 64'o0525252525252525252525;
      for (int i = 0; i < 4; i++) begin
         drive(64'hFFFF_FFFF_FFFF_FFFF ^ (64'h1 << i), pats[i]);
         check_all("R2");
         drive({$urandom, $urandom}, pats[i]);
         check_all("R3");
         drive(pats[i], pats[3 - i]);
         check_all("R4");
      end
   endtask

   // R5, R7, R10: random operands across every legal segment size
   task automatic t_random();
      for (int i = 0; i < 40; i++) begin
         drive({$urandom, $urandom}, {$urandom, $urandom});
         if (i % 3 == 0)      check_all("R5");
         else if (i % 3 == 1) check_all("R7");
         else                 check_all("R10");
      end
   endtask

   // R8: capture on in_valid, hold and drop valid when idle
   task automatic t_hold();
      logic [63:0] e48;
      logic [63:0] e12;
      drive(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
      check_all("R8");
      e48 = refm(64'(a48), 64'(b48), 48);
      e12 = refm(64'(a12), 64'(b12), 12);
      in_valid = 1'b0;
      a48 = 48'h5; b48 = 48'h7; a12 = 12'h5; b12 = 12'h7;
      @(negedge clk);
      chk("R8", "idle valid", 64'(ov), 64'h0);
      chk("R8", "idle hold w48", 64'(p48x), e48);
      chk("R8", "idle hold w12", 64'(p12y), e12);
      @(negedge clk);
      chk("R8", "idle hold w48 2nd", 64'(p48y), e48);
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_corners();
      t_digits();
      t_random();
      t_hold();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule